// File: doc/BRIEF.md
# GF(2^8) Field Multiplier

This block multiplies two 8-bit elements of the finite field GF(2^8) and returns their 8-bit field product. The field is defined by the fixed reduction polynomial x^8+x^4+x^3+x+1 (9'h11B). Addition and subtraction in the field are both bitwise XOR, so the product is formed without carries. The block is used as a drop-in arithmetic primitive by datapaths such as pixel scramblers or coding engines that need one field product per clock.

The multiplier is fully combinational. It is an unrolled chain of eight shift-and-add stages that scans the second operand from its most significant bit to its least significant bit. Each stage first doubles the running value in the field: it shifts left, and when the bit shifted out is set it XORs in the low byte of the polynomial. It then XORs in the first operand if the current bit of the second operand is set. The unregistered product appears at an output port in the same cycle. An optional output stage, selected by a parameter, captures the product on a rising edge while the input strobe is high. A matching valid flag follows one cycle later.

Top module: `gfm_mult`

## Requirements
- R1: The product of 0x23, 0x5F, 0xB7 and 0xFF, each times 0xAA, is 0x79, 0x31, 0xEF and 0xEB respectively, and appears on `prod_comb` in the same cycle as the operands.
- R2: When either operand is 0x00, `prod_comb` is 0x00.
- R3: When `op_b` is 0x01, `prod_comb` equals `op_a`. When `op_a` is 0x01, `prod_comb` equals `op_b`.
- R4: Swapping the operands leaves `prod_comb` unchanged.
- R5: For any operand pair, `prod_comb` equals the field product reduced by x^8+x^4+x^3+x+1 (9'h11B), where addition is XOR.
- R6: With the output stage enabled, `prod_q` takes the current `prod_comb` on a rising clock edge where `in_valid` is 1. On an edge where `in_valid` is 0 it holds its value.
- R7: `out_valid` on each edge takes the value `in_valid` had before that edge. While `rst_n` is 0, `out_valid` and `prod_q` are 0.
- R8: Multiplication distributes over field addition: a*(b XOR c) equals (a*b) XOR (a*c).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Strobe that loads the output stage |
| op_a | input | 8 | First field operand (multiplicand) |
| op_b | input | 8 | Second field operand (multiplier, scanned MSB first) |
| prod_comb | output | 8 | Unregistered field product |
| prod_q | output | 8 | Registered field product |
| out_valid | output | 1 | Strobe delayed one cycle, marks `prod_q` as new |

## Verification
The assertions check on every cycle the properties that relate ports directly. A zero operand must give a zero product, and a unit operand must pass the other operand through. The output stage must load on a strobe and hold without one, and the valid flag must trail the strobe by exactly one edge. The algebraic behaviour can only be shown by the bench's scenarios, which compare against an independent bit-serial model. This covers the known products, commutativity and distributivity over random pairs, and exhaustive sweeps of one operand.

// File: rtl/gfm_pkg.sv
package gfm_pkg;

    // Field width and fixed reduction polynomial x^8+x^4+x^3+x+1
    localparam int unsigned GF_W    = 8;
    localparam logic [GF_W:0] GF_POLY = 9'h11B;

    typedef logic [GF_W-1:0] gf_elem_t;

endpackage

// File: rtl/gfm_step.sv
// One shift-and-add stage: doubles the running value in the field,
// then conditionally adds (XORs) the multiplicand.
module gfm_step #(
    parameter int unsigned W       = 8,
    parameter logic [W-1:0] POLY_LO = 8'h1B
) (
    input  logic [W-1:0] acc_in,
    input  logic [W-1:0] mcand,
    input  logic         mbit,
    output logic [W-1:0] acc_out
);

    logic [W-1:0] doubled;
    logic         carry;

    always_comb begin
        carry   = acc_in[W-1];
        doubled = {acc_in[W-2:0], 1'b0};
        if (carry) begin
            doubled = doubled ^ POLY_LO;
        end
        acc_out = doubled ^ (mbit ? mcand : '0);
    end

endmodule

// File: rtl/gfm_chain.sv
// Unrolled chain of W stages scanning the multiplier MSB first.
module gfm_chain #(
    parameter int unsigned W       = 8,
    parameter logic [W-1:0] POLY_LO = 8'h1B
) (
    input  logic [W-1:0] mcand,
    input  logic [W-1:0] mplier,
    output logic [W-1:0] product
);

    logic [W-1:0] acc [W+1];

    assign acc[0] = '0;

    for (genvar i = 0; i < W; i++) begin : g_stage
        gfm_step #(
            .W       (W),
            .POLY_LO (POLY_LO)
        ) u_step (
            .acc_in  (acc[i]),
            .mcand   (mcand),
            .mbit    (mplier[W-1-i]),
            .acc_out (acc[i+1])
        );
    end

    assign product = acc[W];

endmodule

// File: rtl/gfm_outreg.sv
// Optional output capture stage with a one-cycle valid flag.
module gfm_outreg #(
    parameter int unsigned W       = 8,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         out_valid
);

    if (REG_OUT) begin : g_reg
        logic [W-1:0] q_r;
        logic         v_r;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q_r <= '0;
                v_r <= 1'b0;
            end else begin
                v_r <= in_valid;
                if (in_valid) begin
                    q_r <= d;
                end
            end
        end

        assign q         = q_r;
        assign out_valid = v_r;

        // R6
        load_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (q == $past(d)));

        // R6
        hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(q));

        // R7
        valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);

        // R7
        valid_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
    end else begin : g_pass
        assign q         = d;
        assign out_valid = in_valid;
    end

endmodule

// File: rtl/gfm_mult.sv
// GF(2^8) multiplier top: combinational product plus optional register.
module gfm_mult
    import gfm_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [GF_W-1:0] op_a,
    input  logic [GF_W-1:0] op_b,
    output logic [GF_W-1:0] prod_comb,
    output logic [GF_W-1:0] prod_q,
    output logic            out_valid
);

    localparam logic [GF_W-1:0] POLY_LO = GF_POLY[GF_W-1:0];

    gf_elem_t product_w;

    gfm_chain #(
        .W       (GF_W),
        .POLY_LO (POLY_LO)
    ) u_chain (
        .mcand   (op_a),
        .mplier  (op_b),
        .product (product_w)
    );

    assign prod_comb = product_w;

    gfm_outreg #(
        .W       (GF_W),
        .REG_OUT (REG_OUT)
    ) u_outreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .d         (product_w),
        .q         (prod_q),
        .out_valid (out_valid)
    );

    // R2
    zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_a == '0) || (op_b == '0)) |-> (prod_comb == '0));

    // R3
    unit_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_b == GF_W'(1)) |-> (prod_comb == op_a));

    // R3
    unit_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_a == GF_W'(1)) |-> (prod_comb == op_b));

endmodule

// File: tb/tb_gfm_mult.sv
module tb_gfm_mult;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] op_a = '0;
    logic [7:0] op_b = '0;
    logic [7:0] prod_comb;
    logic [7:0] prod_q;
    logic       out_valid;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q = '0;

    always #10 clk = ~clk;

    gfm_mult #(.REG_OUT(1'b1)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .prod_comb (prod_comb),
        .prod_q    (prod_q),
        .out_valid (out_valid)
    );

    // Bit-serial reference: scans the multiplier LSB first, doubling the multiplicand
    function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        logic [8:0] sh;
        logic [7:0] p;
        sh = {1'b0, a};
        p  = '0;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ sh[7:0];
            sh = sh << 1;
            if (sh[8]) sh = sh ^ 9'h11B;
        end
        return p;
    endfunction

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Present operands at a falling edge, check the combinational product,
    // then check the output stage just after the next rising edge.
    task automatic apply(input string req, input logic [7:0] a, input logic [7:0] b,
                         input logic v, input logic [7:0] exp);
        @(negedge clk);
        op_a = a; op_b = b; in_valid = v;
        #1;
        check8(req, prod_comb, exp);
        @(posedge clk);
        #1;
        if (v) exp_q = exp;
        check8("R6", prod_q, exp_q);
        check8("R7", {7'd0, out_valid}, {7'd0, v});
    endtask

    task automatic comb_val(input logic [7:0] a, input logic [7:0] b, output logic [7:0] r);
        @(negedge clk);
        op_a = a; op_b = b; in_valid = 1'b0;
        #1;
        r = prod_comb;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] r1, r2, r3;
        logic [7:0] a, b, c;
        void'($urandom(32'd4242));

        // Reset state (R7)
        repeat (3) @(posedge clk);
        #1;
        check8("R7", prod_q, 8'h00);
        check8("R7", {7'd0, out_valid}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // Known products (R1)
        apply("R1", 8'h23, 8'hAA, 1'b1, 8'h79);
        apply("R1", 8'h5F, 8'hAA, 1'b1, 8'h31);
        apply("R1", 8'hB7, 8'hAA, 1'b1, 8'hEF);
        apply("R1", 8'hFF, 8'hAA, 1'b1, 8'hEB);

        // Hold without strobe (R6): prod_q must keep 0xEB
        apply("R6", 8'h12, 8'h34, 1'b0, ref_mul(8'h12, 8'h34));
        apply("R6", 8'h80, 8'h80, 1'b0, ref_mul(8'h80, 8'h80));

        // Zero and unit operands over every other value (R2, R3)
        for (int i = 0; i < 256; i++) begin
            apply("R2", 8'(i), 8'h00, i[0], 8'h00);
            apply("R2", 8'h00, 8'(i), 1'b1, 8'h00);
            apply("R3", 8'(i), 8'h01, i[1], 8'(i));
            apply("R3", 8'h01, 8'(i), 1'b1, 8'(i));
        end

        // Exhaustive sweep of one operand against a few fixed ones (R5)
        for (int i = 0; i < 256; i++) begin
            apply("R5", 8'(i), 8'h80, 1'b1, ref_mul(8'(i), 8'h80));
            apply("R5", 8'hFF, 8'(i), i[2], ref_mul(8'hFF, 8'(i)));
        end

        // Random pairs against the reference model (R5)
        for (int i = 0; i < 2000; i++) begin
            a = 8'($urandom);
            b = 8'($urandom);
            apply("R5", a, b, 1'($urandom), ref_mul(a, b));
        end

        // Commutativity (R4)
        for (int i = 0; i < 300; i++) begin
            a = 8'($urandom);
            b = 8'($urandom);
            comb_val(a, b, r1);
            comb_val(b, a, r2);
            check8("R4", r2, r1);
        end

        // Distributivity over XOR (R8)
        for (int i = 0; i < 300; i++) begin
            a = 8'($urandom);
            b = 8'($urandom);
            c = 8'($urandom);
            comb_val(a, b, r1);
            comb_val(a, c, r2);
            comb_val(a, b ^ c, r3);
            check8("R8", r3, r1 ^ r2);
        end

        // Reset in mid-run clears the output stage (R7)
        apply("R7", 8'h57, 8'h83, 1'b1, 8'hC1);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check8("R7", prod_q, 8'h00);
        check8("R7", {7'd0, out_valid}, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule